// File: doc/BRIEF.md
# Register Access Command Engine

This block is the controller-side executor for register-access mailbox commands. A command word and a 16-byte write buffer arrive from the mailbox. One start pulse hands them over. The engine unpacks a list of 16-bit register addresses and carries out one of three operations on a byte-wide register file:

- a batched read,
- a batched write,
- a masked read-modify-write.

It works through a simple synchronous register port and issues one access per cycle in item order. A batched read leaves its result bytes in a 16-byte read buffer. When the command finishes, a one-cycle done pulse goes out together with an error code.

The command word keeps its mailbox layout:

- bits [7:0] are the message code,
- bits [15:12] select the operation,
- bits [23:16] give the size.

A neighbouring mailbox block decodes these fields, so their positions are fixed. Byte b of the write buffer and of the read buffer is bits [8b+7:8b] of the flat port. The register port has a one-cycle read latency: `rf_rdata_i` shows the addressed byte in the cycle after the clock edge at which the port sees a read.

Top module: `regacc_engine`

## Requirements
- R1: Only commands whose code field (bits [7:0]) equals 0xFF are executed. Any other code finishes with error 0x01 and makes no register access. This check wins over all others. Bits [11:8] and [31:24] of the command word are ignored.
- R2: The operation field (bits [15:12]) selects the operation: 0 is a batched write, 1 a batched read, 2 a read-modify-write. Any other value finishes with error 0x02 and makes no register access.
- R3: The size field (bits [23:16]) must have a valid value for the operation, or the command finishes with error 0x03 and makes no register access:
  - read: twice an item count of 1 to 5;
  - write: three times an item count of 1 to 5;
  - read-modify-write: exactly 4.
- R4: Item k uses the address whose low byte is write-buffer byte 2k and whose high byte is byte 2k+1. Items are accessed in increasing k.
- R5: A batched read issues its reads on consecutive cycles. Result k goes to read-buffer byte k, and every read-buffer byte at or above the item count reads 0.
- R6: A batched write of N items takes data byte k from write-buffer byte 2N+k. It issues the writes on consecutive cycles.
- R7: A read-modify-write first reads the address in bytes 0 and 1. Two cycles later it writes (old AND NOT mask) OR (value AND mask) to the same address. The value is in byte 2 and the mask in byte 3.
- R8: Done is a one-cycle pulse. Counting clock edges after the edge that accepts start, it comes after:
  - N+2 edges for an N-item read or write,
  - 5 edges for a read-modify-write,
  - 1 edge for a rejected command.
  The error code is 0 on success and holds until the next command is accepted.
- R9: A start pulse that arrives while a command is still executing is ignored.
- R10: Writes, read-modify-writes and rejected commands leave the read buffer unchanged.
- R11: After reset, done, the error code and the register port enable are 0 and the read buffer is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: command word and write buffer are valid |
| cmd_i | input | 32 | Command word (code [7:0], operation [15:12], size [23:16]) |
| wbuf_i | input | 128 | Write buffer, byte b at bits [8b+7:8b] |
| rf_en_o | output | 1 | Register port access strobe |
| rf_we_o | output | 1 | Register port write select (1 write, 0 read) |
| rf_addr_o | output | 16 | Register port address |
| rf_wdata_o | output | 8 | Register port write data |
| rf_rdata_i | input | 8 | Register port read data, valid one cycle after a read |
| rbuf_o | output | 128 | Read buffer, result k at bits [8k+7:8k] |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 8 | Completion status: 0 ok, 0x01 code, 0x02 operation, 0x03 size |

## Verification
The bench builds the engine with its default parameters: a five-item batch limit and a 16-byte buffer. With these values a full five-item write fills 15 of the 16 buffer bytes, which exercises the data offset at its largest value. Sizes meaning six items are also within reach and must be rejected. Every size is small enough that the exact done latency and the cycle of each register access can be checked against each command.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  // command word layout shared with the mailbox block
  localparam int CMD_W     = 32;
  localparam int CODE_LSB  = 0;
  localparam int OPSEL_LSB = 12;
  localparam int SIZE_LSB  = 16;
  localparam int ADDR_W    = 16;
  localparam int BYTE_W    = 8;

  // write-buffer positions of the read-modify-write operands
  localparam int RMW_VAL_IX = 2;
  localparam int RMW_MSK_IX = 3;
  localparam logic [7:0] RMW_SIZE = 8'd4;

  localparam logic [7:0] ERR_NONE  = 8'h00;
  localparam logic [7:0] ERR_CODE  = 8'h01;
  localparam logic [7:0] ERR_OPSEL = 8'h02;
  localparam logic [7:0] ERR_SIZE  = 8'h03;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_RD  = 2'd1,
    OP_RMW = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_GAP,
    S_MERGE,
    S_TAIL,
    S_FIN
  } seq_st_e;

endpackage

// File: rtl/regacc_decode.sv
module regacc_decode
  import regacc_pkg::*;
#(
  parameter int         MAX_ITEMS = 5,
  parameter int         CNT_W     = 3,
  parameter logic [7:0] MSG_CODE  = 8'hFF
) (
  input  logic [CMD_W-1:0] cmd_i,
  output op_e              op_o,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       err_o
);

  logic [7:0] code;
  logic [3:0] opsel;
  logic [7:0] size;
  logic       size_ok;
  logic       unused_cmd_bits;

  assign code  = cmd_i[CODE_LSB +: 8];
  assign opsel = cmd_i[OPSEL_LSB +: 4];
  assign size  = cmd_i[SIZE_LSB +: 8];
  assign unused_cmd_bits = ^{cmd_i[11:8], cmd_i[31:24]};

  always_comb begin
    op_o    = OP_BAD;
    count_o = '0;
    size_ok = 1'b0;
    case (opsel)
      4'd0: begin
        op_o = OP_WR;
        for (int k = 1; k <= MAX_ITEMS; k++) begin
          if (size == 8'(3 * k)) begin
            size_ok = 1'b1;
            count_o = CNT_W'(k);
          end
        end
      end
      4'd1: begin
        op_o = OP_RD;
        for (int k = 1; k <= MAX_ITEMS; k++) begin
          if (size == 8'(2 * k)) begin
            size_ok = 1'b1;
            count_o = CNT_W'(k);
          end
        end
      end
      4'd2: begin
        op_o = OP_RMW;
        if (size == RMW_SIZE) begin
          size_ok = 1'b1;
          count_o = CNT_W'(1);
        end
      end
      default: op_o = OP_BAD;
    endcase
  end

  // priority: message code, then operation select, then size
  always_comb begin
    if (code != MSG_CODE)    err_o = ERR_CODE;
    else if (op_o == OP_BAD) err_o = ERR_OPSEL;
    else if (!size_ok)       err_o = ERR_SIZE;
    else                     err_o = ERR_NONE;
  end

endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_ITEMS = 5,
  parameter int CNT_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [BUF_BYTES*8-1:0]  wbuf_i,
  input  op_e                     dec_op_i,
  input  logic [CNT_W-1:0]        dec_count_i,
  input  logic [7:0]              dec_err_i,
  input  logic [BYTE_W-1:0]       rf_rdata_i,
  output logic                    rf_en_o,
  output logic                    rf_we_o,
  output logic [ADDR_W-1:0]       rf_addr_o,
  output logic [BYTE_W-1:0]       rf_wdata_o,
  output logic                    rd_v_o,
  output logic [CNT_W-1:0]        rd_idx_o,
  output logic                    clr_o,
  output logic                    done_o,
  output logic [7:0]              err_o
);

  localparam int BIW = $clog2(BUF_BYTES);

  seq_st_e          st_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx_q;
  logic [BYTE_W-1:0] buf_q [BUF_BYTES];
  logic [BIW-1:0]   lo_ix, hi_ix, dat_ix;
  logic             accept;

  assign accept = (st_q == S_IDLE) && start_i;
  assign clr_o  = accept && (dec_err_i == ERR_NONE) && (dec_op_i == OP_RD);

  // item addressing inside the latched write buffer
  assign lo_ix  = BIW'(idx_q) << 1;
  assign hi_ix  = lo_ix + 1'b1;
  assign dat_ix = (BIW'(cnt_q) << 1) + BIW'(idx_q);

  // write-buffer copy, no reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int b = 0; b < BUF_BYTES; b++) buf_q[b] <= wbuf_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      op_q       <= OP_BAD;
      cnt_q      <= '0;
      idx_q      <= '0;
      rf_en_o    <= 1'b0;
      rf_we_o    <= 1'b0;
      rf_addr_o  <= '0;
      rf_wdata_o <= '0;
      rd_v_o     <= 1'b0;
      rd_idx_o   <= '0;
      done_o     <= 1'b0;
      err_o      <= ERR_NONE;
    end else begin
      rf_en_o <= 1'b0;
      rd_v_o  <= 1'b0;
      done_o  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            op_q  <= dec_op_i;
            cnt_q <= dec_count_i;
            idx_q <= '0;
            err_o <= dec_err_i;
            st_q  <= (dec_err_i != ERR_NONE) ? S_FIN : S_ISSUE;
          end
        end
        S_ISSUE: begin
          rf_en_o    <= 1'b1;
          rf_we_o    <= (op_q == OP_WR);
          rf_addr_o  <= {buf_q[hi_ix], buf_q[lo_ix]};
          rf_wdata_o <= buf_q[dat_ix];
          rd_v_o     <= (op_q == OP_RD);
          rd_idx_o   <= idx_q;
          idx_q      <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) st_q <= (op_q == OP_RMW) ? S_GAP : S_TAIL;
        end
        S_GAP: st_q <= S_MERGE;   // read data lands on the port
        S_MERGE: begin
          rf_en_o    <= 1'b1;
          rf_we_o    <= 1'b1;
          rf_wdata_o <= (rf_rdata_i & ~buf_q[RMW_MSK_IX]) |
                        (buf_q[RMW_VAL_IX] & buf_q[RMW_MSK_IX]);
          st_q       <= S_TAIL;
        end
        S_TAIL: st_q <= S_FIN;    // last access completes, last result captured
        S_FIN: begin
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rf_en_o && rf_we_o && op_q == OP_RMW) |->
      ($past(rf_en_o, 2) && !$past(rf_we_o, 2) && rf_addr_o == $past(rf_addr_o, 2))); // R7

  AST_ISSUE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ISSUE) |-> (idx_q < cnt_q)); // R3

endmodule

// File: rtl/regacc_rbuf.sv
module regacc_rbuf
  import regacc_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_ITEMS = 5,
  parameter int CNT_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic                   rd_v_i,
  input  logic [CNT_W-1:0]       rd_idx_i,
  input  logic [BYTE_W-1:0]      rdata_i,
  output logic [BUF_BYTES*8-1:0] rbuf_o
);

  logic             pend_v;
  logic [CNT_W-1:0] pend_idx;

  // the port answers one cycle after the access strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      pend_idx <= '0;
    end else begin
      pend_v   <= rd_v_i;
      pend_idx <= rd_idx_i;
    end
  end

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    if (b < MAX_ITEMS) begin : g_cap
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst || clr_i)                      byte_q <= '0;
        else if (pend_v && int'(pend_idx) == b) byte_q <= rdata_i;
      end
      assign rbuf_o[8*b +: 8] = byte_q;
    end else begin : g_zero
      assign rbuf_o[8*b +: 8] = '0;
    end
  end

  AST_CAPTURE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> (int'(pend_idx) < MAX_ITEMS)); // R5

endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
  import regacc_pkg::*;
#(
  parameter int         BUF_BYTES = 16,
  parameter int         MAX_ITEMS = 5,
  parameter logic [7:0] MSG_CODE  = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [31:0]            cmd_i,
  input  logic [BUF_BYTES*8-1:0] wbuf_i,
  output logic                   rf_en_o,
  output logic                   rf_we_o,
  output logic [15:0]            rf_addr_o,
  output logic [7:0]             rf_wdata_o,
  input  logic [7:0]             rf_rdata_i,
  output logic [BUF_BYTES*8-1:0] rbuf_o,
  output logic                   done_o,
  output logic [7:0]             err_code_o
);

  localparam int CNT_W = $clog2(MAX_ITEMS + 1);

  op_e              dec_op;
  logic [CNT_W-1:0] dec_count;
  logic [7:0]       dec_err;
  logic             rd_v;
  logic [CNT_W-1:0] rd_idx;
  logic             clr;

  regacc_decode #(
    .MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W), .MSG_CODE(MSG_CODE)
  ) u_decode (
    .cmd_i   (cmd_i),
    .op_o    (dec_op),
    .count_o (dec_count),
    .err_o   (dec_err)
  );

  regacc_seq #(
    .BUF_BYTES(BUF_BYTES), .MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .wbuf_i      (wbuf_i),
    .dec_op_i    (dec_op),
    .dec_count_i (dec_count),
    .dec_err_i   (dec_err),
    .rf_rdata_i  (rf_rdata_i),
    .rf_en_o     (rf_en_o),
    .rf_we_o     (rf_we_o),
    .rf_addr_o   (rf_addr_o),
    .rf_wdata_o  (rf_wdata_o),
    .rd_v_o      (rd_v),
    .rd_idx_o    (rd_idx),
    .clr_o       (clr),
    .done_o      (done_o),
    .err_o       (err_code_o)
  );

  regacc_rbuf #(
    .BUF_BYTES(BUF_BYTES), .MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W)
  ) u_rbuf (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .rd_v_i   (rd_v),
    .rd_idx_i (rd_idx),
    .rdata_i  (rf_rdata_i),
    .rbuf_o   (rbuf_o)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_code_o != ERR_NONE) |-> (!rf_en_o && !$past(rf_en_o))); // R3

  AST_REJECT_KEEPS_RBUF: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_code_o != ERR_NONE) |-> $stable(rbuf_o)); // R10

endmodule

// File: tb/sim_regacc_engine.sv
module sim_regacc_engine;

  typedef struct packed {
    logic [31:0]  cmd;
    logic [127:0] wb;
    logic [7:0]   err;
    logic [7:0]   lat;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h0006_00FF, 128'h0000_0000_0000_0000_0000_8877_A521_A520, 8'h00, 8'd4},
    '{32'h0006_10FF, 128'h0000_0000_0000_0000_0000_A530_A521_A520, 8'h00, 8'd5},
    '{32'h000F_00FF, 128'h0005_0403_0201_A544_A543_A542_A541_A540, 8'h00, 8'd7},
    '{32'h000A_10FF, 128'h0000_0000_0000_A543_A541_A542_A540_A544, 8'h00, 8'd7},
    '{32'h0004_21FF, 128'h0000_0000_0000_0000_0000_0000_3CF0_A521, 8'h00, 8'd5},
    '{32'h0002_11FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h00, 8'd3},
    '{32'h0002_10FE, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h01, 8'd1},
    '{32'h0002_30FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h02, 8'd1},
    '{32'h000C_10FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h03, 8'd1},
    '{32'h0000_10FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h03, 8'd1},
    '{32'h0003_10FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h03, 8'd1},
    '{32'h0004_00FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h03, 8'd1},
    '{32'h0012_00FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h03, 8'd1},
    '{32'h0002_20FF, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h03, 8'd1},
    '{32'h0002_50AA, 128'h0000_0000_0000_0000_0000_0000_0000_A521, 8'h01, 8'd1},
    '{32'hFF02_10FF, 128'h0000_0000_0000_0000_0000_0000_0000_A544, 8'h00, 8'd3},
    '{32'h0003_00FF, 128'h0000_0000_0000_0000_0000_0000_0099_A530, 8'h00, 8'd3},
    '{32'h0004_20FF, 128'h0000_0000_0000_0000_0000_0000_FF12_A530, 8'h00, 8'd5},
    '{32'h0004_10FF, 128'h0000_0000_0000_0000_0000_0000_A521_A530, 8'h00, 8'd4}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  cmd = '0;
  logic [127:0] wbuf = '0;
  logic         rf_en, rf_we;
  logic [15:0]  rf_addr;
  logic [7:0]   rf_wdata;
  logic [7:0]   rf_rdata;
  logic [127:0] rbuf;
  logic         done;
  logic [7:0]   err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0]  mem [256];
  logic [7:0]  sh  [256];
  logic [15:0] log_a [64];
  logic        log_w [64];
  logic [7:0]  log_d [64];
  int          log_t [64];
  int          log_n;

  always #2 clk = ~clk;

  regacc_engine u0 (
    .clk(clk), .rst(rst), .start_i(start), .cmd_i(cmd), .wbuf_i(wbuf),
    .rf_en_o(rf_en), .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata),
    .rf_rdata_i(rf_rdata), .rbuf_o(rbuf), .done_o(done), .err_code_o(err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // register file model with one-cycle read latency and an access log
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
      rf_rdata <= '0;
      log_n    <= 0;
    end else if (rf_en) begin
      if (rf_we) mem[rf_addr[7:0]] <= rf_wdata;
      else       rf_rdata <= mem[rf_addr[7:0]];
      if (log_n < 64) begin
        log_a[log_n] <= rf_addr;
        log_w[log_n] <= rf_we;
        log_d[log_n] <= rf_wdata;
        log_t[log_n] <= cyc;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err == 8'h01) return "R1";
    if (v.err == 8'h02) return "R2";
    if (v.err == 8'h03) return "R3";
    if (v.cmd[15:12] == 4'd0) return "R6";
    if (v.cmd[15:12] == 4'd1) return "R5";
    return "R7";
  endfunction

  task automatic run_vec(input vec_t v);
    int base, lat, n, nacc;
    logic [127:0] prev, exp_rb;
    logic [15:0] a;
    logic [7:0] m, val, merged;
    string t;
    t = tag_of(v);
    @(negedge clk);
    base = log_n;
    prev = rbuf;
    start = 1'b1; cmd = v.cmd; wbuf = v.wb;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == int'(v.lat), "R8", "done latency", 128'(lat), 128'(v.lat));
    chk(err == v.err, t, "error code", 128'(err), 128'(v.err));
    if (v.err == 8'h00) begin
      n = (v.cmd[15:12] == 4'd1) ? int'(v.cmd[23:16]) / 2 :
          (v.cmd[15:12] == 4'd0) ? int'(v.cmd[23:16]) / 3 : 1;
      nacc = (v.cmd[15:12] == 4'd2) ? 2 : n;
      chk(log_n - base == nacc, t, "access count", 128'(log_n - base), 128'(nacc));
      if (v.cmd[15:12] == 4'd2) begin
        a = {v.wb[15:8], v.wb[7:0]};
        val = v.wb[23:16];
        m = v.wb[31:24];
        merged = (sh[a[7:0]] & ~m) | (val & m);
        chk(log_a[base] == a && !log_w[base], "R7", "rmw read", {log_w[base], log_a[base]}, {1'b0, a});
        chk(log_a[base+1] == a && log_w[base+1], "R7", "rmw write", {log_w[base+1], log_a[base+1]}, {1'b1, a});
        chk(log_t[base+1] == log_t[base] + 2, "R7", "rmw spacing", 128'(log_t[base+1] - log_t[base]), 128'(2));
        chk(log_d[base+1] == merged, "R7", "rmw merged data", 128'(log_d[base+1]), 128'(merged));
        sh[a[7:0]] = merged;
        chk(rbuf == prev, "R10", "read buffer after rmw", rbuf, prev);
      end else begin
        exp_rb = '0;
        for (int k = 0; k < n; k++) begin
          a = {v.wb[8*(2*k+1) +: 8], v.wb[8*(2*k) +: 8]};
          chk(log_a[base+k] == a, "R4", "item address", 128'(log_a[base+k]), 128'(a));
          chk(log_w[base+k] == (v.cmd[15:12] == 4'd0), t, "access direction",
              128'(log_w[base+k]), 128'(v.cmd[15:12] == 4'd0));
          chk(log_t[base+k] == log_t[base] + k, t, "back-to-back issue",
              128'(log_t[base+k] - log_t[base]), 128'(k));
          if (v.cmd[15:12] == 4'd0) begin
            chk(log_d[base+k] == v.wb[8*(2*n+k) +: 8], "R6", "write data",
                128'(log_d[base+k]), 128'(v.wb[8*(2*n+k) +: 8]));
            sh[a[7:0]] = v.wb[8*(2*n+k) +: 8];
          end else begin
            exp_rb[8*k +: 8] = sh[a[7:0]];
          end
        end
        if (v.cmd[15:12] == 4'd1) chk(rbuf == exp_rb, "R5", "read buffer", rbuf, exp_rb);
        else                      chk(rbuf == prev, "R10", "read buffer after write", rbuf, prev);
      end
    end else begin
      chk(log_n == base, t, "no access on reject", 128'(log_n - base), 128'(0));
      chk(rbuf == prev, "R10", "read buffer after reject", rbuf, prev);
    end
    @(negedge clk);
    chk(!done, "R8", "done is a single pulse", 128'(done), 128'(0));
    chk(err == v.err, "R8", "error code held", 128'(err), 128'(v.err));
  endtask

  initial begin
    int base, dones;
    vec_t vb;
    for (int i = 0; i < 256; i++) sh[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: state after reset
    chk(!done && err == 8'h00 && !rf_en, "R11", "reset outputs", {done, rf_en, err}, '0);
    chk(rbuf == '0, "R11", "reset read buffer", rbuf, '0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: second start during a 5-item read is ignored
    @(negedge clk);
    base = log_n;
    dones = 0;
    start = 1'b1; cmd = 32'h000A_10FF; wbuf = 128'h0000_0000_0000_A543_A541_A542_A540_A544;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; cmd = 32'h0003_00FF; wbuf = 128'h0000_0000_0000_0000_0000_0000_0055_A520;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk(dones == 1, "R9", "done count with busy start", 128'(dones), 128'(1));
    chk(log_n - base == 5, "R9", "accesses with busy start", 128'(log_n - base), 128'(5));
    for (int k = 0; k < 5; k++)
      chk(!log_w[base+k], "R9", "no write from busy start", 128'(log_w[base+k]), 128'(0));
    vb = '{32'h0002_10FF, 128'h0000_0000_0000_0000_0000_0000_0000_A520, 8'h00, 8'd3};
    run_vec(vb);
    chk(rbuf[7:0] == 8'h77, "R9", "register untouched by busy start", 128'(rbuf[7:0]), 128'(8'h77));

    // R11: reset clears the read buffer again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rbuf == '0 && !done && err == 8'h00, "R11", "second reset", rbuf, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule